// File: doc/BRIEF.md
# Predicated First-Set Mask Generator

This block takes a source mask with one bit per element, a predicate mask that says which elements take part, and a two-bit operation code. It finds the lowest-numbered active element whose source bit is 1, then builds a destination mask around that element. Three shapes are offered: ones below that element, ones up to and including it, or a single one on that element. Element 0 is the least significant bit and the scan runs toward higher indices.

Predication changes the search itself. A set source bit in an inactive element is never taken as the first one. Inactive destination positions are not computed: they are copied from a previous-destination input, so the whole result is defined. A separate enable switches predication off, and then every element is active. The inputs are captured on a valid strobe and the result appears, with its own valid flag, on the next clock.

Top module: `first_mark_gen`

## Requirements
- R1: With opSel = 2'b00 (before-first), every active element below the lowest active element with a source 1 gets 1. That element and every active element above it get 0. Element 0 is the least significant bit and the scan starts there.
- R2: With opSel = 2'b01 (including-first), the result is the before-first result with the first active set element also written with 1.
- R3: With opSel = 2'b10 (only-first), the first active element with a source 1 gets 1 and every other active element gets 0.
- R4: When no active element has a source 1, before-first and including-first write 1 to every active element, and only-first writes 0 to every active element.
- R5: A source bit of 1 in an inactive element (predOn = 1 and predMask bit = 0) is never taken as the first set element.
- R6: For opSel 2'b00, 2'b01 and 2'b10, every inactive destination bit takes the value of the matching prevDest bit.
- R7: With predOn = 0, every element is active whatever predMask holds.
- R8: With opSel = 2'b11, the whole destMask is 0, including the inactive positions.
- R9: outValid is 1 in exactly the cycle after a cycle in which inValid is 1, and destMask carries that request's result in the same cycle.
- R10: Synchronous active-high reset clears outValid and destMask to 0.
- R11: After a cycle in which inValid is 0, destMask keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe: inputs are captured on this edge |
| opSel | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 all zero |
| srcMask | input | WIDTH | Source mask, bit 0 = element 0 |
| predMask | input | WIDTH | Predicate mask: 1 = active element |
| predOn | input | 1 | 1 applies predMask, 0 makes every element active |
| prevDest | input | WIDTH | Values given to the inactive destination bits |
| outValid | output | 1 | Result valid, one cycle after inValid |
| destMask | output | WIDTH | Registered destination mask |

## Verification
The hardest case is a source whose lowest set bit sits in an inactive element while a higher active element is also set. The block must skip the inactive one, and the right answer differs from what an unpredicated scan gives. Directed vectors place set bits in masked-off low positions ahead of active ones. A long random phase then draws the source and predicate densely enough that this overlap keeps recurring. It also draws prevDest at random, so any inactive bit that is recomputed instead of copied shows up as a mismatch.

// File: rtl/fmk_pkg.sv
package fmk_pkg;

  typedef enum logic [1:0] {
    OP_BEFORE  = 2'b00,
    OP_INCLUDE = 2'b01,
    OP_ONLY    = 2'b10,
    OP_ZERO    = 2'b11
  } fmkOp_e;

  // Strobes the control half hands to the datapath for one capture.
  typedef struct packed {
    logic capture;
    logic pickBefore;
    logic pickIncl;
    logic pickOnly;
    logic forceZero;
  } fmkStrobe_t;

endpackage

// File: rtl/fmk_ctrl.sv
module fmk_ctrl
  import fmk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output fmkStrobe_t stb,
  output logic       outValid
);

  fmkOp_e opDec;

  always_comb begin
    opDec          = fmkOp_e'(opSel);
    stb            = '0;
    stb.capture    = inValid;
    stb.pickBefore = (opDec == OP_BEFORE);
    stb.pickIncl   = (opDec == OP_INCLUDE);
    stb.pickOnly   = (opDec == OP_ONLY);
    stb.forceZero  = (opDec == OP_ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // Exactly one operation is selected on every capture.
  pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    stb.capture |-> $onehot({stb.pickBefore, stb.pickIncl, stb.pickOnly, stb.forceZero}));

endmodule

// File: rtl/fmk_datapath.sv
module fmk_datapath
  import fmk_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  fmkStrobe_t       stb,
  input  logic [WIDTH-1:0] srcMask,
  input  logic [WIDTH-1:0] predMask,
  input  logic             predOn,
  input  logic [WIDTH-1:0] prevDest,
  output logic [WIDTH-1:0] destMask
);

  localparam int CHAIN = WIDTH + 1;

  logic [WIDTH-1:0] actMask;
  logic [WIDTH-1:0] hitMask;
  logic [CHAIN-1:0] seenChain;   // seenChain[i]: an active hit below element i
  logic [WIDTH-1:0] belowFirst;
  logic [WIDTH-1:0] uptoFirst;
  logic [WIDTH-1:0] atFirst;
  logic [WIDTH-1:0] opResult;
  logic [WIDTH-1:0] merged;

  assign actMask      = predOn ? predMask : '1;
  assign hitMask      = srcMask & actMask;
  assign seenChain[0] = 1'b0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_scan
      assign seenChain[i+1] = seenChain[i] | hitMask[i];
      assign atFirst[i]     = hitMask[i] & ~seenChain[i];
      assign uptoFirst[i]   = ~seenChain[i];
      assign belowFirst[i]  = ~seenChain[i] & ~hitMask[i];
    end
  endgenerate

  always_comb begin
    opResult = '0;
    if (stb.pickBefore) opResult = belowFirst;
    if (stb.pickIncl)   opResult = uptoFirst;
    if (stb.pickOnly)   opResult = atFirst;
    merged = (opResult & actMask) | (prevDest & ~actMask);
    if (stb.forceZero) merged = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)              destMask <= '0;
    else if (stb.capture) destMask <= merged;
  end

  // R3
  only_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && stb.pickOnly) |=> $onehot0(destMask & $past(actMask)));

  // R6
  inactive_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && !stb.forceZero) |=>
      ((destMask & ~$past(actMask)) == ($past(prevDest) & ~$past(actMask))));

  // R8
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && stb.forceZero) |=> (destMask == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.capture |=> $stable(destMask));

  // R10
  always @(posedge clk) begin
    if (!rst && $past(rst)) begin
      reset_clear_chk: assert (destMask == '0);
    end
  end

endmodule

// File: rtl/first_mark_gen.sv
module first_mark_gen
  import fmk_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcMask,
  input  logic [WIDTH-1:0] predMask,
  input  logic             predOn,
  input  logic [WIDTH-1:0] prevDest,
  output logic             outValid,
  output logic [WIDTH-1:0] destMask
);

  fmkStrobe_t stb;

  fmk_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opSel    (opSel),
    .stb      (stb),
    .outValid (outValid)
  );

  fmk_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .srcMask  (srcMask),
    .predMask (predMask),
    .predOn   (predOn),
    .prevDest (prevDest),
    .destMask (destMask)
  );

endmodule

// File: tb/first_mark_gen_tb.sv
module first_mark_gen_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] srcMask = '0;
  logic [W-1:0] predMask = '0;
  logic         predOn = 1'b0;
  logic [W-1:0] prevDest = '0;
  logic         outValid;
  logic [W-1:0] destMask;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  logic         expValid = 1'b0;
  logic [W-1:0] expDest = '0;
  string        phaseTag = "R10";
  string        expTag = "R10";

  always #2 clk = ~clk;

  first_mark_gen #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .srcMask(srcMask), .predMask(predMask), .predOn(predOn),
    .prevDest(prevDest), .outValid(outValid), .destMask(destMask)
  );

  // Behavioural element-by-element reference.
  function automatic logic [W-1:0] refMask(logic [W-1:0] src, logic [W-1:0] pred,
                                           logic on, logic [1:0] op, logic [W-1:0] prev);
    logic [W-1:0] r;
    bit found;
    r = '0;
    found = 0;
    if (op == 2'b11) return '0;
    for (int i = 0; i < W; i++) begin
      if (!on || pred[i]) begin
        if (src[i] && !found) begin
          r[i] = (op != 2'b00);
          found = 1;
        end else begin
          r[i] = (op != 2'b10) && !found;
        end
      end else begin
        r[i] = prev[i];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      expValid = 1'b0;
      expDest  = '0;
      expTag   = "R10";
    end else begin
      expValid = inValid;
      if (inValid) begin
        expDest = refMask(srcMask, predMask, predOn, opSel, prevDest);
        expTag  = phaseTag;
      end else if (expTag != "R10") begin
        expTag = "R11";
      end
    end
  end

  task automatic compareNow();
    compared++;
    if (outValid !== expValid || destMask !== expDest) begin
      mismatched++;
      $display("FAIL %s: outValid=%0b destMask=%h expected outValid=%0b destMask=%h (R9 timing)",
               expTag, outValid, destMask, expValid, expDest);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [W-1:0] s,
                      input logic [W-1:0] p, input logic on, input logic [W-1:0] pv,
                      input string tag);
    @(negedge clk);
    compareNow();
    inValid = v; opSel = op; srcMask = s; predMask = p; predOn = on; prevDest = pv;
    phaseTag = tag;
  endtask

  initial begin
    // R10: reset state held for a few cycles
    for (int k = 0; k < 4; k++) step(1'b1, 2'b01, 16'h00F0, '1, 1'b0, '1, "R10");
    rst = 1'b0;
    // R1 basic, scan from bit 0
    step(1'b1, 2'b00, 16'h0094, '0, 1'b0, '0, "R1");
    step(1'b1, 2'b00, 16'h0095, '0, 1'b0, '0, "R1");
    // R2, R3
    step(1'b1, 2'b01, 16'h0094, '0, 1'b0, '0, "R2");
    step(1'b1, 2'b10, 16'h0094, '0, 1'b0, '0, "R3");
    step(1'b1, 2'b10, 16'h0095, '0, 1'b0, '0, "R3");
    // R4: no set bit at all
    step(1'b1, 2'b00, 16'h0000, '0, 1'b0, '0, "R4");
    step(1'b1, 2'b01, 16'h0000, '0, 1'b0, '0, "R4");
    step(1'b1, 2'b10, 16'h0000, '0, 1'b0, '1, "R4");
    // R5/R6: set bits only in inactive low elements, random-looking prevDest
    step(1'b1, 2'b00, 16'h0094, 16'h00C3, 1'b1, 16'hA5A5, "R5");
    step(1'b1, 2'b01, 16'h0094, 16'h00C3, 1'b1, 16'h5A5A, "R5");
    step(1'b1, 2'b10, 16'h00D4, 16'h00C3, 1'b1, 16'hFFFF, "R6");
    step(1'b1, 2'b00, 16'h000F, 16'hFFF0, 1'b1, 16'h0000, "R5");
    // R7: predOn low ignores predMask
    step(1'b1, 2'b10, 16'h0094, 16'h0000, 1'b0, 16'hFFFF, "R7");
    // R8: zero op clears inactive bits too
    step(1'b1, 2'b11, 16'hFFFF, 16'h00FF, 1'b1, 16'hFFFF, "R8");
    // R11: hold with idle cycles and changing inputs
    step(1'b1, 2'b01, 16'h8000, 16'hFFFF, 1'b1, '0, "R2");
    step(1'b0, 2'b11, 16'h0001, 16'h1234, 1'b1, '1, "R11");
    step(1'b0, 2'b10, 16'h0002, 16'h0000, 1'b0, '1, "R11");
    // Random phase: every requirement re-exercised, R9 timing each cycle
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      string t;
      op = 2'($urandom);
      t = (op == 2'b00) ? "R1" : (op == 2'b01) ? "R2" : (op == 2'b10) ? "R3" : "R8";
      step(($urandom % 4) != 0, op, W'($urandom) & W'($urandom), W'($urandom),
           ($urandom % 5) != 0, W'($urandom), t);
      if (k == 1500) begin
        rst = 1'b1;
        step(1'b1, 2'b00, '1, '1, 1'b0, '1, "R10");
        step(1'b1, 2'b00, '1, '1, 1'b0, '1, "R10");
        rst = 1'b0;
      end
    end
    step(1'b0, 2'b00, '0, '0, 1'b0, '0, "R11");
    step(1'b0, 2'b00, '0, '0, 1'b0, '0, "R11");
    done = 1;
  end

  initial begin
    wait (done || cycles > 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule